// File: doc/BRIEF.md
# Priority Banked Address Mapper

This block turns a 24-bit bus address into a single device select and a device-local address. The address is split into an 8-bit bank and a 16-bit offset. The devices behind it are:

- a boot ROM;
- a 512K pseudo-SRAM;
- an optional extra memory;
- a removable data pack of up to 4M;
- a 32K battery SRAM;
- a window of sixteen control ports.

The logic is purely combinational. A set of applied configuration bits (indices 2 to 12) chooses the layout:

- **Paged layout:** upper or lower 32K halves of each bank.
- **Linear layout:** full 64K banks.
- It also sets where the pseudo-SRAM sits and which regions are enabled in the low banks and in the high banks.

Four regions can cover the same address. A fixed priority picks the winner: boot ROM, then pseudo-SRAM, then extra memory, then data pack. The SRAM and control windows never collide with anything.

An access with no winner gives an open-bus indication instead of a select. So does an access won by an unfitted device, and so does a write to the data pack while its write enable is clear. The system places the block between the bus strobes and the memory selects. It feeds the block the applied bits from the control register file.

Top module: `bank_mapper`

## Requirements
- R1: `cs_o` has one bit per device: bit0 boot ROM, bit1 pseudo-SRAM, bit2 extra memory, bit3 data pack, bit4 SRAM, bit5 control window. At most one bit is set. While neither `rd_i` nor `wr_i` is high, `cs_o` is zero and `open_bus_o` is low.
- R2: Banks 00h-7Dh form the low area and banks 80h-FFh the high area; banks 7Eh-7Fh belong to no region and read as open bus.
- R3: The boot ROM decodes at offsets 8000h-FFFFh of banks 00h-3Fh when cfg bit 7 is set, and of banks 80h-BFh when cfg bit 8 is set. It uses the paged layout in both modes, with address {bank[4:0], ofs[14:0]}.
- R4: In paged mode (cfg bit 2 = 0), cfg bits 6-5 give the pseudo-SRAM placement, enabled by bit 3 (low area) or bit 4 (high area):
  - 0: banks x0h-xFh, upper half only;
  - 1: banks x20h-x2Fh, upper half only;
  - 2: banks x40h-x4Fh, whole bank;
  - 3: banks x60h-x6Fh, whole bank.
  Here x stands for the area bit. The address is {bank[3:0], ofs[14:0]}, so both halves of a whole bank alias.
- R5: In paged mode, offsets 0000h-7FFFh of banks 70h-7Dh and F0h-FFh always map the pseudo-SRAM, at {bank[3:0], ofs[14:0]}. Bits 6-5 have no effect there; bits 3-4 still enable it.
- R6: In linear mode (cfg bit 2 = 1), cfg bits 6-5 pick the eight whole banks {area,1,sel,0xxx}. The matching banks {area,0,sel,0xxx} show only offsets 8000h-FFFFh. The address is {bank[2:0], ofs}.
- R7: In linear mode, offsets 6000h-7FFFh of banks 20h-3Fh and A0h-BFh map the pseudo-SRAM at {bank[2:0], ofs}, whatever bits 6-5 are. The area enables (bits 3-4) still apply.
- R8: The extra memory is enabled by cfg bit 9 (low area) or bit 10 (high area), and cfg bit 11 picks the placement.
  - Paged mode: banks 00h-1Fh upper halves, or 40h-5Fh whole banks.
  - Linear mode: 00h-0Fh or 20h-2Fh upper halves, plus 40h-4Fh or 60h-6Fh whole banks.
  - Address: {bank[5:0], ofs[14:0]} in paged mode, {bank[3:0], ofs} in linear mode.
  - With the default `EXT_FITTED`=0 a winning hit gives open bus.
- R9: The data pack covers upper halves of banks 00h-3Fh/80h-BFh and whole banks 40h-7Dh/C0h-FFh, with no enable bit. Its address is {bank[6:0], ofs[14:0]} in paged mode and {bank[5:0], ofs} in linear mode.
- R10: A write that the data pack wins gives open bus and no select unless cfg bit 12 is set. Reads and writes to other devices ignore bit 12.
- R11: Overlaps resolve as boot ROM over pseudo-SRAM over extra memory over data pack.
- R12: The SRAM sits at offsets 5000h-5FFFh of banks 10h-17h, address {bank[2:0], ofs[11:0]}. The control window sits at 5000h-5FFFh of banks 00h-0Fh, index bank[3:0]. All other 5000h-7FFFh space not claimed under R7 is open bus.
- R13: An active access where no region matches drives `open_bus_o` high and `cs_o` to zero; open bus and a select are never both asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bank_i | input | 8 | Bank part of the bus address |
| ofs_i | input | 16 | Offset within the bank |
| rd_i | input | 1 | Read strobe |
| wr_i | input | 1 | Write strobe |
| cfg_i | input | 11 | Applied configuration bits, indices 12 down to 2 |
| cs_o | output | 6 | One-hot device select |
| open_bus_o | output | 1 | Access hits no fitted, permitted device |
| boot_addr_o | output | 20 | Boot ROM address |
| psram_addr_o | output | 19 | Pseudo-SRAM address |
| ext_addr_o | output | 20 | Extra memory address |
| pack_addr_o | output | 22 | Data pack address |
| sram_addr_o | output | 15 | SRAM address |
| ctrl_idx_o | output | 4 | Control port index |

## Verification
The hardest cases to reach are addresses claimed by two or three regions at once. In those cases the loser's address is still computed but must not be selected. The stimulus builds configurations that deliberately stack regions:

- the boot ROM over a relocated pseudo-SRAM;
- linear-mode pseudo-SRAM mirrors over the boot ROM;
- an enabled but unfitted extra memory that must mask the data pack underneath as open bus.

The linear-mode 8K windows and the always-mapped lower halves are reached by choosing bank and offset pairs that no relocation setting should affect. The same pairs are repeated under a different placement code.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
  localparam int unsigned BANK_W     = 8;
  localparam int unsigned OFS_W      = 16;
  localparam int unsigned RAW_W      = 24;
  localparam int unsigned CTRL_IDX_W = 4;
  localparam int unsigned NDEV       = 6;

  // device index == priority rank for the overlapping four
  localparam int unsigned DEV_BOOT  = 0;
  localparam int unsigned DEV_PSRAM = 1;
  localparam int unsigned DEV_EXT   = 2;
  localparam int unsigned DEV_PACK  = 3;
  localparam int unsigned DEV_SRAM  = 4;
  localparam int unsigned DEV_CTRL  = 5;

  // configuration bit positions
  localparam int unsigned CFG_LINEAR  = 2;
  localparam int unsigned CFG_PS_LO   = 3;
  localparam int unsigned CFG_PS_HI   = 4;
  localparam int unsigned CFG_PS_SEL0 = 5;
  localparam int unsigned CFG_PS_SEL1 = 6;
  localparam int unsigned CFG_BT_LO   = 7;
  localparam int unsigned CFG_BT_HI   = 8;
  localparam int unsigned CFG_EX_LO   = 9;
  localparam int unsigned CFG_EX_HI   = 10;
  localparam int unsigned CFG_EX_ALT  = 11;
  localparam int unsigned CFG_PK_WE   = 12;

  localparam logic [6:0] LO_AREA_END = 7'h7E;

  // variants of the ROM-space decoder
  localparam int unsigned ROM_BOOT = 0;
  localparam int unsigned ROM_EXT  = 1;
  localparam int unsigned ROM_PACK = 2;
endpackage

// File: rtl/bank_mapper_win.sv
module bank_mapper_win
  import bank_mapper_pkg::*;
#(
  parameter int unsigned SRAM_AW = 15
) (
  input  logic [BANK_W-1:0]     bank_i,
  input  logic [OFS_W-1:0]      ofs_i,
  output logic                  sram_hit_o,
  output logic                  ctrl_hit_o,
  output logic [SRAM_AW-1:0]    sram_addr_o,
  output logic [CTRL_IDX_W-1:0] ctrl_idx_o
);
  logic             in_5k;
  logic [RAW_W-1:0] sram_raw;

  assign in_5k       = (ofs_i[15:12] == 4'h5);
  assign sram_hit_o  = in_5k && (bank_i[7:3] == 5'b00010);
  assign ctrl_hit_o  = in_5k && (bank_i[7:4] == 4'h0);
  assign sram_raw    = RAW_W'({bank_i[2:0], ofs_i[11:0]});
  assign sram_addr_o = sram_raw[SRAM_AW-1:0];
  assign ctrl_idx_o  = bank_i[CTRL_IDX_W-1:0];
endmodule

// File: rtl/bank_mapper_psram.sv
module bank_mapper_psram
  import bank_mapper_pkg::*;
#(
  parameter int unsigned AW = 19
) (
  input  logic [BANK_W-1:0] bank_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic              linear_i,
  input  logic              en_lo_i,
  input  logic              en_hi_i,
  input  logic [1:0]        sel_i,
  output logic              hit_o,
  output logic [AW-1:0]     addr_o
);
  logic [6:0]       bb;
  logic             hi_area, in_area, en;
  logic             pg_move, pg_fixed, ln_group, ln_snip;
  logic [RAW_W-1:0] raw;

  assign bb      = bank_i[6:0];
  assign hi_area = bank_i[7];
  assign in_area = hi_area | (bb < LO_AREA_END);
  assign en      = in_area & (hi_area ? en_hi_i : en_lo_i);

  // paged: relocatable 16-bank block, full bank for codes 2/3
  assign pg_move  = (bb[6:4] == {sel_i, 1'b0}) && (sel_i[1] || ofs_i[15]);
  // paged: lower halves of the top 16 banks, placement independent
  assign pg_fixed = (bb[6:4] == 3'b111) && !ofs_i[15];
  // linear: eight whole banks plus their upper-half mirrors
  assign ln_group = (bb[5:4] == sel_i) && !bb[3] && (bb[6] || ofs_i[15]);
  // linear: 8K windows at 6000h-7FFFh
  assign ln_snip  = (bb[6:5] == 2'b01) && (ofs_i[15:13] == 3'b011);

  always_comb begin
    if (linear_i) begin
      hit_o = en && (ln_group || ln_snip);
      raw   = RAW_W'({bb[2:0], ofs_i});
    end else begin
      hit_o = en && (pg_move || pg_fixed);
      raw   = RAW_W'({bb[3:0], ofs_i[14:0]});
    end
  end

  assign addr_o = raw[AW-1:0];
endmodule

// File: rtl/bank_mapper_rom.sv
module bank_mapper_rom
  import bank_mapper_pkg::*;
#(
  parameter int unsigned KIND = ROM_PACK,
  parameter int unsigned AW   = 22
) (
  input  logic [BANK_W-1:0] bank_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic              linear_i,
  input  logic              en_lo_i,
  input  logic              en_hi_i,
  input  logic              alt_i,
  output logic              hit_o,
  output logic [AW-1:0]     addr_o
);
  logic [6:0]       bb;
  logic             hi_area, in_area, en;
  logic [RAW_W-1:0] raw;

  assign bb      = bank_i[6:0];
  assign hi_area = bank_i[7];
  assign in_area = hi_area | (bb < LO_AREA_END);
  assign en      = in_area & (hi_area ? en_hi_i : en_lo_i);

  generate
    if (KIND == ROM_BOOT) begin : g_boot
      logic unused_boot;
      assign unused_boot = ^{linear_i, alt_i};
      assign hit_o = en && !bb[6] && ofs_i[15];
      assign raw   = RAW_W'({bb[5:0], ofs_i[14:0]});
    end else if (KIND == ROM_EXT) begin : g_ext
      logic pg_hit, ln_hit;
      assign pg_hit = alt_i ? (bb[6:5] == 2'b10)
                            : ((bb[6:5] == 2'b00) && ofs_i[15]);
      assign ln_hit = (bb[5] == alt_i) && !bb[4] && (bb[6] || ofs_i[15]);
      assign hit_o  = en && (linear_i ? ln_hit : pg_hit);
      assign raw    = linear_i ? RAW_W'({bb[3:0], ofs_i})
                               : RAW_W'({bb[5:0], ofs_i[14:0]});
    end else begin : g_pack
      logic unused_pack;
      assign unused_pack = ^{alt_i};
      assign hit_o = en && (bb[6] || ofs_i[15]);
      assign raw   = linear_i ? RAW_W'({bb[5:0], ofs_i})
                              : RAW_W'({bb[6:0], ofs_i[14:0]});
    end
  endgenerate

  assign addr_o = raw[AW-1:0];
endmodule

// File: rtl/bank_mapper_arb.sv
module bank_mapper_arb #(
  parameter int unsigned          N      = 6,
  parameter logic [N-1:0]         FITTED = '1
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o,
  output logic         none_o,
  output logic         unfit_o
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_rank
      if (i == 0) begin : g_top
        assign gnt_o[i] = req_i[i];
      end else begin : g_rest
        assign gnt_o[i] = req_i[i] && !(|req_i[i-1:0]);
      end
    end
  endgenerate

  assign none_o  = ~|req_i;
  assign unfit_o = |(gnt_o & ~FITTED);
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
  import bank_mapper_pkg::*;
#(
  parameter int unsigned BOOT_AW    = 20,
  parameter int unsigned PSRAM_AW   = 19,
  parameter int unsigned EXT_AW     = 20,
  parameter int unsigned PACK_AW    = 22,
  parameter int unsigned SRAM_AW    = 15,
  parameter bit          EXT_FITTED = 1'b0
) (
  input  logic [7:0]          bank_i,
  input  logic [15:0]         ofs_i,
  input  logic                rd_i,
  input  logic                wr_i,
  input  logic [12:2]         cfg_i,
  output logic [5:0]          cs_o,
  output logic                open_bus_o,
  output logic [BOOT_AW-1:0]  boot_addr_o,
  output logic [PSRAM_AW-1:0] psram_addr_o,
  output logic [EXT_AW-1:0]   ext_addr_o,
  output logic [PACK_AW-1:0]  pack_addr_o,
  output logic [SRAM_AW-1:0]  sram_addr_o,
  output logic [3:0]          ctrl_idx_o
);
  localparam logic [NDEV-1:0] EXT_BIT = NDEV'(1) << DEV_EXT;
  localparam logic [NDEV-1:0] FITTED  = EXT_FITTED ? '1 : ~EXT_BIT;

  logic [NDEV-1:0] req, gnt;
  logic            none, unfit, acc, pack_wr_block;

  bank_mapper_rom #(.KIND(ROM_BOOT), .AW(BOOT_AW)) u_boot (
    .bank_i, .ofs_i,
    .linear_i (cfg_i[CFG_LINEAR]),
    .en_lo_i  (cfg_i[CFG_BT_LO]),
    .en_hi_i  (cfg_i[CFG_BT_HI]),
    .alt_i    (1'b0),
    .hit_o    (req[DEV_BOOT]),
    .addr_o   (boot_addr_o)
  );

  bank_mapper_psram #(.AW(PSRAM_AW)) u_psram (
    .bank_i, .ofs_i,
    .linear_i (cfg_i[CFG_LINEAR]),
    .en_lo_i  (cfg_i[CFG_PS_LO]),
    .en_hi_i  (cfg_i[CFG_PS_HI]),
    .sel_i    ({cfg_i[CFG_PS_SEL1], cfg_i[CFG_PS_SEL0]}),
    .hit_o    (req[DEV_PSRAM]),
    .addr_o   (psram_addr_o)
  );

  bank_mapper_rom #(.KIND(ROM_EXT), .AW(EXT_AW)) u_ext (
    .bank_i, .ofs_i,
    .linear_i (cfg_i[CFG_LINEAR]),
    .en_lo_i  (cfg_i[CFG_EX_LO]),
    .en_hi_i  (cfg_i[CFG_EX_HI]),
    .alt_i    (cfg_i[CFG_EX_ALT]),
    .hit_o    (req[DEV_EXT]),
    .addr_o   (ext_addr_o)
  );

  bank_mapper_rom #(.KIND(ROM_PACK), .AW(PACK_AW)) u_pack (
    .bank_i, .ofs_i,
    .linear_i (cfg_i[CFG_LINEAR]),
    .en_lo_i  (1'b1),
    .en_hi_i  (1'b1),
    .alt_i    (1'b0),
    .hit_o    (req[DEV_PACK]),
    .addr_o   (pack_addr_o)
  );

  bank_mapper_win #(.SRAM_AW(SRAM_AW)) u_win (
    .bank_i, .ofs_i,
    .sram_hit_o  (req[DEV_SRAM]),
    .ctrl_hit_o  (req[DEV_CTRL]),
    .sram_addr_o (sram_addr_o),
    .ctrl_idx_o  (ctrl_idx_o)
  );

  bank_mapper_arb #(.N(NDEV), .FITTED(FITTED)) u_arb (
    .req_i   (req),
    .gnt_o   (gnt),
    .none_o  (none),
    .unfit_o (unfit)
  );

  assign acc           = rd_i | wr_i;
  assign pack_wr_block = gnt[DEV_PACK] && wr_i && !cfg_i[CFG_PK_WE];
  assign open_bus_o    = acc && (none || unfit || pack_wr_block);
  assign cs_o          = (acc && !open_bus_o) ? gnt : '0;
endmodule

// File: rtl/bank_mapper_chk.sv
module bank_mapper_chk #(
  parameter int unsigned BOOT_AW  = 20,
  parameter int unsigned PSRAM_AW = 19,
  parameter int unsigned EXT_AW   = 20,
  parameter int unsigned PACK_AW  = 22,
  parameter int unsigned SRAM_AW  = 15
) (
  input logic [7:0]          bank_i,
  input logic [15:0]         ofs_i,
  input logic                rd_i,
  input logic                wr_i,
  input logic [12:2]         cfg_i,
  input logic [5:0]          cs_o,
  input logic                open_bus_o,
  input logic [BOOT_AW-1:0]  boot_addr_o,
  input logic [PSRAM_AW-1:0] psram_addr_o,
  input logic [EXT_AW-1:0]   ext_addr_o,
  input logic [PACK_AW-1:0]  pack_addr_o,
  input logic [SRAM_AW-1:0]  sram_addr_o,
  input logic [3:0]          ctrl_idx_o
);
  logic unused_chk;
  assign unused_chk = ^{boot_addr_o, psram_addr_o, ext_addr_o, pack_addr_o,
                        sram_addr_o, ctrl_idx_o, cfg_i[11:2]};

  always_comb begin
    assert_onehot_R1: assert ($onehot0(cs_o));
    if (!(rd_i || wr_i)) begin
      assert_idle_R1: assert (cs_o == '0 && !open_bus_o);
    end else begin
      assert_outcome_R13: assert (open_bus_o != (cs_o != '0));
    end
    if (bank_i[7:1] == 7'h3F) begin
      assert_gap_R2: assert (cs_o == '0);
    end
    if (cs_o[0]) begin
      assert_boot_win_R3: assert (!bank_i[6] && ofs_i[15]);
    end
    if (cs_o[3] && wr_i) begin
      assert_pack_we_R10: assert (cfg_i[12]);
    end
    if (cs_o[4]) begin
      assert_sram_win_R12: assert (bank_i[7:3] == 5'b00010 && ofs_i[15:12] == 4'h5);
    end
    if (cs_o[5]) begin
      assert_ctrl_win_R12: assert (bank_i[7:4] == 4'h0 && ofs_i[15:12] == 4'h5);
    end
  end
endmodule

bind bank_mapper bank_mapper_chk u_chk (.*);

// File: tb/bank_mapper_test.sv
`timescale 1ns/1ps
module bank_mapper_test;
  localparam int A_BOOT = 0, A_PSRAM = 1, A_EXT = 2, A_PACK = 3,
                 A_SRAM = 4, A_CTRL = 5, A_NONE = 6;
  localparam logic [5:0] C_BOOT = 6'h01, C_PSRAM = 6'h02, C_PACK = 6'h08,
                         C_SRAM = 6'h10, C_CTRL = 6'h20, C_NONE = 6'h00;

  typedef struct {
    logic [5:0]  cs;
    logic        open;
    int          sel;
    logic [23:0] addr;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [7:0] bank = '0;
  logic [15:0] ofs = '0;
  logic rd = 1'b0, wr = 1'b0;
  logic [12:2] cfg = '0;
  logic [5:0] cs;
  logic open_bus;
  logic [19:0] boot_addr;
  logic [18:0] psram_addr;
  logic [19:0] ext_addr;
  logic [21:0] pack_addr;
  logic [14:0] sram_addr;
  logic [3:0] ctrl_idx;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  exp_t exp_q[$];
  exp_t e;

  always #5 clk = ~clk;

  bank_mapper uut (
    .bank_i(bank), .ofs_i(ofs), .rd_i(rd), .wr_i(wr), .cfg_i(cfg),
    .cs_o(cs), .open_bus_o(open_bus),
    .boot_addr_o(boot_addr), .psram_addr_o(psram_addr), .ext_addr_o(ext_addr),
    .pack_addr_o(pack_addr), .sram_addr_o(sram_addr), .ctrl_idx_o(ctrl_idx)
  );

  function automatic logic [12:2] mkcfg(input bit lin, input bit ps_lo, input bit ps_hi,
                                        input logic [1:0] sel, input bit bt_lo, input bit bt_hi,
                                        input bit ex_lo, input bit ex_hi, input bit ex_alt,
                                        input bit we);
    logic [12:2] c;
    c = '0;
    c[2] = lin; c[3] = ps_lo; c[4] = ps_hi; c[6:5] = sel;
    c[7] = bt_lo; c[8] = bt_hi; c[9] = ex_lo; c[10] = ex_hi;
    c[11] = ex_alt; c[12] = we;
    return c;
  endfunction

  function automatic logic [23:0] port_addr(input int sel);
    case (sel)
      A_BOOT:  return 24'(boot_addr);
      A_PSRAM: return 24'(psram_addr);
      A_EXT:   return 24'(ext_addr);
      A_PACK:  return 24'(pack_addr);
      A_SRAM:  return 24'(sram_addr);
      A_CTRL:  return 24'(ctrl_idx);
      default: return 24'h0;
    endcase
  endfunction

  task automatic drive(input logic [7:0] b, input logic [15:0] o, input logic r,
                       input logic w, input logic [12:2] c, input logic [5:0] ecs,
                       input logic eop, input int esel, input logic [23:0] ea,
                       input string tag);
    exp_t x;
    @(posedge clk);
    #1;
    bank = b; ofs = o; rd = r; wr = w; cfg = c;
    x.cs = ecs; x.open = eop; x.sel = esel; x.addr = ea; x.tag = tag;
    exp_q.push_back(x);
  endtask

  // monitor: compare at the falling edge, one item per cycle
  always @(negedge clk) begin
    if (rst_ni && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      total++;
      if (cs !== e.cs || open_bus !== e.open ||
          (e.sel != A_NONE && port_addr(e.sel) !== e.addr)) begin
        bad++;
        $display("FAIL %s: cs=%h open=%b addr=%h expected cs=%h open=%b addr=%h",
                 e.tag, cs, open_bus, port_addr(e.sel), e.cs, e.open, e.addr);
      end
    end
  end

  initial begin : watchdog
    #2000000;
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    logic [12:2] c;
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1 idle bus
    drive(8'h00, 16'h8000, 0, 0, '0, C_NONE, 0, A_NONE, 0, "R1 idle");
    drive(8'h13, 16'h5ABC, 0, 0, '0, C_NONE, 0, A_NONE, 0, "R1 idle on sram");

    // R3 boot ROM
    c = mkcfg(0,0,0,2'd0,1,0,0,0,0,0);
    drive(8'h05, 16'h9234, 1, 0, c, C_BOOT, 0, A_BOOT, 24'h29234, "R3 boot low");
    drive(8'h85, 16'h9234, 1, 0, c, C_PACK, 0, A_PACK, 24'h29234, "R2 high area not boot-enabled");
    c = mkcfg(0,0,0,2'd0,0,1,0,0,0,0);
    drive(8'h9F, 16'hFFFF, 1, 0, c, C_BOOT, 0, A_BOOT, 24'hFFFFF, "R3 boot high");

    // R11 priority
    c = mkcfg(0,1,0,2'd0,1,0,0,0,0,0);
    drive(8'h03, 16'h8000, 1, 0, c, C_BOOT, 0, A_BOOT, 24'h18000, "R11 boot over psram");
    c = mkcfg(1,1,0,2'd2,1,0,0,0,0,0);
    drive(8'h25, 16'h8123, 1, 0, c, C_BOOT, 0, A_BOOT, 24'h28123, "R11 boot over linear psram");

    // R4 paged psram placements
    c = mkcfg(0,1,0,2'd0,0,0,0,0,0,0);
    drive(8'h03, 16'h8010, 1, 0, c, C_PSRAM, 0, A_PSRAM, 24'h18010, "R4 sel0");
    c = mkcfg(0,1,0,2'd1,0,0,0,0,0,0);
    drive(8'h2A, 16'hC000, 1, 0, c, C_PSRAM, 0, A_PSRAM, 24'h54000, "R4 sel1");
    drive(8'h03, 16'h8010, 1, 0, c, C_PACK, 0, A_PACK, 24'h18010, "R4 sel1 leaves bank 03");
    c = mkcfg(0,0,1,2'd2,0,0,0,0,0,0);
    drive(8'hC7, 16'h1234, 1, 0, c, C_PSRAM, 0, A_PSRAM, 24'h39234, "R4 sel2 lower half");
    drive(8'hC7, 16'h9234, 1, 0, c, C_PSRAM, 0, A_PSRAM, 24'h39234, "R4 sel2 upper alias");
    drive(8'h47, 16'h1234, 1, 0, c, C_PACK, 0, A_PACK, 24'h239234, "R4 sel2 low area disabled");
    c = mkcfg(0,1,0,2'd3,0,0,0,0,0,0);
    drive(8'h6F, 16'h0000, 1, 0, c, C_PSRAM, 0, A_PSRAM, 24'h78000, "R4 sel3");

    // R5 fixed lower halves
    c = mkcfg(0,1,0,2'd0,0,0,0,0,0,0);
    drive(8'h7D, 16'h7FFF, 1, 0, c, C_PSRAM, 0, A_PSRAM, 24'h6FFFF, "R5 bank 7D");
    drive(8'h7D, 16'h8000, 1, 0, c, C_PACK, 0, A_PACK, 24'h3E8000, "R5 upper half is pack");
    c = mkcfg(0,0,1,2'd1,0,0,0,0,0,0);
    drive(8'hFF, 16'h0001, 1, 0, c, C_PSRAM, 0, A_PSRAM, 24'h78001, "R5 bank FF sel1");

    // R2 area gap
    drive(8'h7E, 16'h8000, 1, 0, '0, C_NONE, 1, A_NONE, 0, "R2 bank 7E");
    drive(8'hFE, 16'h8000, 1, 0, '0, C_PACK, 0, A_PACK, 24'h3F0000, "R2 bank FE");

    // R6 linear groups
    c = mkcfg(1,1,0,2'd2,0,0,0,0,0,0);
    drive(8'h65, 16'hABCD, 1, 0, c, C_PSRAM, 0, A_PSRAM, 24'h5ABCD, "R6 full bank");
    drive(8'h25, 16'h8123, 1, 0, c, C_PSRAM, 0, A_PSRAM, 24'h58123, "R6 upper mirror");
    drive(8'h25, 16'h0123, 1, 0, c, C_NONE, 1, A_NONE, 0, "R13 lower half unmapped");
    drive(8'h2D, 16'h8000, 1, 0, c, C_PACK, 0, A_PACK, 24'h2D8000, "R9 linear pack upper");

    // R7 linear 8K windows
    c = mkcfg(1,1,0,2'd0,0,0,0,0,0,0);
    drive(8'h3B, 16'h6ABC, 1, 0, c, C_PSRAM, 0, A_PSRAM, 24'h36ABC, "R7 window low");
    c = mkcfg(1,0,1,2'd0,0,0,0,0,0,0);
    drive(8'hBB, 16'h7000, 1, 0, c, C_PSRAM, 0, A_PSRAM, 24'h37000, "R7 window high");
    c = mkcfg(1,0,0,2'd0,0,0,0,0,0,0);
    drive(8'h3B, 16'h6ABC, 1, 0, c, C_NONE, 1, A_NONE, 0, "R7 window disabled");
    c = mkcfg(0,1,0,2'd0,0,0,0,0,0,0);
    drive(8'h3B, 16'h6ABC, 1, 0, c, C_NONE, 1, A_NONE, 0, "R12 paged 6000h open");

    // R8 extra memory, not fitted
    c = mkcfg(0,0,0,2'd0,0,0,1,0,0,0);
    drive(8'h12, 16'h9000, 1, 0, c, C_NONE, 1, A_EXT, 24'h91000, "R8 paged ext masks pack");
    c = mkcfg(1,0,0,2'd0,0,0,0,1,1,0);
    drive(8'hE5, 16'h0042, 1, 0, c, C_NONE, 1, A_EXT, 24'h50042, "R8 linear ext alt");
    c = mkcfg(1,0,0,2'd0,0,0,0,0,0,0);
    drive(8'hE5, 16'h0042, 1, 0, c, C_PACK, 0, A_PACK, 24'h250042, "R9 linear pack full bank");
    drive(8'hFF, 16'hFFFF, 1, 0, c, C_PACK, 0, A_PACK, 24'h3FFFFF, "R9 linear pack top");

    // R10 pack write gating
    c = mkcfg(0,0,0,2'd0,0,0,0,0,0,0);
    drive(8'h85, 16'h9234, 0, 1, c, C_NONE, 1, A_NONE, 0, "R10 write blocked");
    drive(8'h85, 16'h9234, 1, 0, c, C_PACK, 0, A_PACK, 24'h29234, "R10 read unaffected");
    c = mkcfg(0,0,0,2'd0,0,0,0,0,0,1);
    drive(8'h85, 16'h9234, 0, 1, c, C_PACK, 0, A_PACK, 24'h29234, "R10 write allowed");

    // R12 fixed windows
    drive(8'h13, 16'h5ABC, 1, 0, '0, C_SRAM, 0, A_SRAM, 24'h3ABC, "R12 sram");
    drive(8'h14, 16'h5001, 0, 1, '0, C_SRAM, 0, A_SRAM, 24'h4001, "R10 sram write ignores we");
    drive(8'h0A, 16'h5FFF, 1, 0, '0, C_CTRL, 0, A_CTRL, 24'hA, "R12 ctrl window");
    drive(8'h93, 16'h5000, 1, 0, '0, C_NONE, 1, A_NONE, 0, "R12 high 5000h open");
    drive(8'h20, 16'h5000, 1, 0, '0, C_NONE, 1, A_NONE, 0, "R12 bank 20 5000h open");

    repeat (4) @(posedge clk);
    if (exp_q.size() != 0) begin
      bad++;
      total++;
      $display("FAIL R1: %0d items unchecked, expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule